// File: doc/BRIEF.md
# Vertical Blanking Measurement-Line Sequencer

This block turns the decoded vertical and horizontal components of a sandcastle timing signal into the line-by-line timing of a vertical blanking interval. A rising vertical level opens a blanking window and clears a line counter. Each following horizontal pulse advances that counter. At fixed line counts, one-hot strobes mark the leakage-current window, the red, green and blue cut-off measurement lines, and the white measurement line. A per-channel pass mask shows which colour channel is released during each of those lines.

A 3-bit standard selector sets where the measurement lines fall. Three codes are interlaced, with one line per measurement. Three codes are progressive, with each measurement covering a pair of lines, a doubled minimum pulse length and a longer counter cycle. The selector is captured when the vertical level rises, so it applies to a whole field. The window closes at the end of the white line, or, if the vertical level is still high then, at the end of the first line that completes after it falls. An over-long vertical level raises a capacitor-discharge request. A vertical level too short to be valid cancels the window.

Top module: `vbl_meas_seq`

## Requirements
- R1: `blank_o` rises in the cycle after the clock edge that first samples `v_level` high. `bright_dis_o` equals `blank_o` at all times. After reset both are 0.
- R2: Selector 000 puts red, green, blue and white on line counts 19, 20, 21, 22. Selector 001 uses 16 to 19 and 010 uses 22 to 25. Line count n is the number of `h_pulse` strobes seen since the vertical level rose. Bit 0 of `cut_o` is red, bit 1 is green and bit 2 is blue.
- R3: Selector 100 uses line pairs starting at 38, 40, 42 and 44. Selector 101 starts them at 32, 34, 36 and 38, and 110 starts them at 44, 46, 48 and 50. Each strobe stays high for two line counts.
- R4: `leak_o` is high from the start of blanking until the line count reaches the first red line. `leak_o`, `cut_o` and `white_o` are never high together.
- R5: If the vertical level falls after fewer than 4 horizontal pulses (8 for codes 100, 101 and 110), blanking ends in the cycle after the fall. Later pulses produce no strobes.
- R6: For a valid pulse that holds v high for V horizontal pulses, blanking ends at horizontal pulse max(W+1, V+1), where W is the white line's last count.
- R7: Once more than 29 horizontal pulses (57 for progressive codes) have occurred with v high, `discharge_o` is high. It stays high until the cycle after v falls, and while it is high `ch_pass_o` is 000.
- R8: Outside blanking `ch_pass_o` is 111. On a cut-off line only the measured channel's bit is 1. On the white line it is 111. On every other blanking line it is 000.
- R9: Selectors 011 and 111 behave exactly like 000, including the interlaced thresholds.
- R10: A change of `std_sel` while blanking is active has no effect until the next rise of v.
- R11: When the line counter wraps (modulo 31 interlaced, 63 progressive) during an over-long vertical level, no strobe repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_pulse | input | 1 | One-cycle strobe per horizontal pulse |
| v_level | input | 1 | Decoded vertical component level |
| std_sel | input | 3 | Standard selector, captured at rise of v |
| blank_o | output | 1 | Vertical blanking window |
| bright_dis_o | output | 1 | Brightness adjustment disable |
| leak_o | output | 1 | Leakage measurement window |
| cut_o | output | 3 | Cut-off line strobes {blue, green, red} |
| white_o | output | 1 | White measurement line strobe |
| ch_pass_o | output | 3 | Channel release mask {blue, green, red} |
| discharge_o | output | 1 | Storage capacitor discharge request |

## Verification
Every output is decoded from registers that are updated at the clock edge sampling the inputs. A change on `v_level` or a strobe on `h_pulse` therefore shows up on the outputs exactly one cycle later, with no combinational path from input to output. The bench changes inputs on the falling clock edge and reads all outputs on the next falling edge, half a cycle after the edge that consumed them. Line-count expectations are worked out from the selector arithmetic, checked after every horizontal pulse and after the vertical fall.

// File: rtl/vbl_pkg.sv
package vbl_pkg;
   localparam int VBL_NSLOT = 4;
   localparam int SLOT_RED = 0;
   localparam int SLOT_GRN = 1;
   localparam int SLOT_BLU = 2;
   localparam int SLOT_WHT = 3;

   typedef logic [2:0] std_sel_t;

   function automatic logic sel_is_prog(input std_sel_t s);
      return (s == 3'b100) || (s == 3'b101) || (s == 3'b110);
   endfunction
endpackage

// File: rtl/vbl_line_table.sv
module vbl_line_table #(
   parameter int LW     = 6,
   parameter int LINE_A = 19,
   parameter int LINE_B = 16,
   parameter int LINE_C = 22,
   parameter int MIN_I  = 4,
   parameter int MIN_P  = 8,
   parameter int DIS_I  = 29,
   parameter int DIS_P  = 57,
   parameter int CYC_I  = 31,
   parameter int CYC_P  = 63
) (
   input  vbl_pkg::std_sel_t sel_i,
   output logic [LW-1:0]     base_o,
   output logic              span_two_o,
   output logic [LW-1:0]     wl_o,
   output logic [LW-1:0]     minv_o,
   output logic [LW-1:0]     dis_thr_o,
   output logic [LW-1:0]     cyc_last_o
);
   localparam int SLOTS = vbl_pkg::VBL_NSLOT;

   logic [LW-1:0] base_i;
   logic          prog;

   assign prog = vbl_pkg::sel_is_prog(sel_i);

   always_comb begin
      unique case (sel_i[1:0])
         2'b01:   base_i = LW'(LINE_B);
         2'b10:   base_i = LW'(LINE_C);
         default: base_i = LW'(LINE_A);
      endcase
      if (sel_i[1:0] == 2'b11) base_i = LW'(LINE_A);
   end

   assign base_o     = prog ? (base_i << 1) : base_i;
   assign span_two_o = prog;
   assign wl_o       = prog ? LW'(base_o + LW'(2*SLOTS - 1)) : LW'(base_o + LW'(SLOTS - 1));
   assign minv_o     = prog ? LW'(MIN_P) : LW'(MIN_I);
   assign dis_thr_o  = prog ? LW'(DIS_P) : LW'(DIS_I);
   assign cyc_last_o = prog ? LW'(CYC_P - 1) : LW'(CYC_I - 1);
endmodule

// File: rtl/vbl_line_counter.sv
module vbl_line_counter #(
   parameter int LW = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              h_pulse,
   input  logic              v_level,
   input  vbl_pkg::std_sel_t std_sel_i,
   input  logic [LW-1:0]     wl_i,
   input  logic [LW-1:0]     minv_i,
   input  logic [LW-1:0]     cyc_last_i,
   output vbl_pkg::std_sel_t sel_q_o,
   output logic [LW-1:0]     lcnt_o,
   output logic [LW-1:0]     vcnt_o,
   output logic              v_q_o,
   output logic              active_o,
   output logic              past_white_o
);
   logic              v_q, active, pw;
   logic [LW-1:0]     lcnt, vcnt;
   vbl_pkg::std_sel_t sel_q;
   logic              v_rise, v_fall, end_line;

   assign v_rise   = v_level && !v_q;
   assign v_fall   = !v_level && v_q;
   assign end_line = !v_level && (pw || (lcnt == wl_i));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q    <= 1'b0;
         active <= 1'b0;
         pw     <= 1'b0;
         lcnt   <= '0;
         vcnt   <= '0;
         sel_q  <= '0;
      end else begin
         v_q <= v_level;
         if (v_rise) begin
            active <= 1'b1;
            pw     <= 1'b0;
            lcnt   <= '0;
            vcnt   <= '0;
            sel_q  <= std_sel_i;
         end else if (active) begin
            if (v_fall && (vcnt < minv_i)) begin
               active <= 1'b0;
            end else if (h_pulse) begin
               if (end_line) begin
                  active <= 1'b0;
               end else begin
                  lcnt <= (lcnt == cyc_last_i) ? '0 : lcnt + 1'b1;
                  if (v_level && (vcnt != '1)) vcnt <= vcnt + 1'b1;
                  if (v_level && (lcnt == wl_i)) pw <= 1'b1;
               end
            end
         end
      end
   end

   assign sel_q_o      = sel_q;
   assign lcnt_o       = lcnt;
   assign vcnt_o       = vcnt;
   assign v_q_o        = v_q;
   assign active_o     = active;
   assign past_white_o = pw;
endmodule

// File: rtl/vbl_strobe_dec.sv
module vbl_strobe_dec #(
   parameter int LW = 6
) (
   input  logic          active_i,
   input  logic          past_white_i,
   input  logic          v_q_i,
   input  logic [LW-1:0] lcnt_i,
   input  logic [LW-1:0] vcnt_i,
   input  logic [LW-1:0] base_i,
   input  logic          span_two_i,
   input  logic [LW-1:0] dis_thr_i,
   output logic          blank_o,
   output logic          leak_o,
   output logic [2:0]    cut_o,
   output logic          white_o,
   output logic [2:0]    pass_o,
   output logic          dis_o
);
   localparam int SLOTS = vbl_pkg::VBL_NSLOT;

   logic             meas_en;
   logic [SLOTS-1:0] hit;
   logic [LW:0]      span;

   assign meas_en = active_i && !past_white_i;
   assign span    = span_two_i ? (LW+1)'(2) : (LW+1)'(1);

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic [LW+2:0] first, last_x;
      assign first  = (LW+3)'(base_i) + (LW+3)'(s) * (LW+3)'(span);
      assign last_x = first + (LW+3)'(span);
      assign hit[s] = meas_en && ((LW+3)'(lcnt_i) >= first) && ((LW+3)'(lcnt_i) < last_x);
   end

   assign blank_o = active_i;
   assign leak_o  = meas_en && (lcnt_i < base_i);
   assign cut_o   = {hit[vbl_pkg::SLOT_BLU], hit[vbl_pkg::SLOT_GRN], hit[vbl_pkg::SLOT_RED]};
   assign white_o = hit[vbl_pkg::SLOT_WHT];
   assign dis_o   = active_i && v_q_i && (vcnt_i > dis_thr_i);

   always_comb begin
      if (!active_i)      pass_o = 3'b111;
      else if (dis_o)     pass_o = 3'b000;
      else if (white_o)   pass_o = 3'b111;
      else                pass_o = cut_o;
   end
endmodule

// File: rtl/vbl_meas_seq.sv
module vbl_meas_seq #(
   parameter int LW     = 6,
   parameter int LINE_A = 19,
   parameter int LINE_B = 16,
   parameter int LINE_C = 22,
   parameter int MIN_I  = 4,
   parameter int MIN_P  = 8,
   parameter int DIS_I  = 29,
   parameter int DIS_P  = 57,
   parameter int CYC_I  = 31,
   parameter int CYC_P  = 63
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       h_pulse,
   input  logic       v_level,
   input  logic [2:0] std_sel,
   output logic       blank_o,
   output logic       bright_dis_o,
   output logic       leak_o,
   output logic [2:0] cut_o,
   output logic       white_o,
   output logic [2:0] ch_pass_o,
   output logic       discharge_o
);
   localparam int MAX_LINE = 2 * LINE_C + 2 * vbl_pkg::VBL_NSLOT;

   if (CYC_P > (1 << LW) - 1) begin : g_bad_cyc
      $error("progressive cycle does not fit the counter width");
   end
   if (MAX_LINE >= CYC_P || LINE_A + vbl_pkg::VBL_NSLOT >= CYC_I) begin : g_bad_line
      $error("measurement lines exceed the counter cycle");
   end
   if (DIS_P >= (1 << LW) - 1 || MIN_P > DIS_P || MIN_I > DIS_I) begin : g_bad_thr
      $error("inconsistent pulse thresholds");
   end

   vbl_pkg::std_sel_t sel_q;
   logic [LW-1:0]     base, wl, minv, dis_thr, cyc_last, lcnt, vcnt;
   logic              span_two, v_q, active, pw;

   vbl_line_table #(
      .LW(LW), .LINE_A(LINE_A), .LINE_B(LINE_B), .LINE_C(LINE_C),
      .MIN_I(MIN_I), .MIN_P(MIN_P), .DIS_I(DIS_I), .DIS_P(DIS_P),
      .CYC_I(CYC_I), .CYC_P(CYC_P)
   ) table_i (
      .sel_i      (sel_q),
      .base_o     (base),
      .span_two_o (span_two),
      .wl_o       (wl),
      .minv_o     (minv),
      .dis_thr_o  (dis_thr),
      .cyc_last_o (cyc_last)
   );

   vbl_line_counter #(.LW(LW)) cnt_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .h_pulse      (h_pulse),
      .v_level      (v_level),
      .std_sel_i    (std_sel),
      .wl_i         (wl),
      .minv_i       (minv),
      .cyc_last_i   (cyc_last),
      .sel_q_o      (sel_q),
      .lcnt_o       (lcnt),
      .vcnt_o       (vcnt),
      .v_q_o        (v_q),
      .active_o     (active),
      .past_white_o (pw)
   );

   vbl_strobe_dec #(.LW(LW)) dec_i (
      .active_i     (active),
      .past_white_i (pw),
      .v_q_i        (v_q),
      .lcnt_i       (lcnt),
      .vcnt_i       (vcnt),
      .base_i       (base),
      .span_two_i   (span_two),
      .dis_thr_i    (dis_thr),
      .blank_o      (blank_o),
      .leak_o       (leak_o),
      .cut_o        (cut_o),
      .white_o      (white_o),
      .pass_o       (ch_pass_o),
      .dis_o        (discharge_o)
   );

   assign bright_dis_o = blank_o;
endmodule

// File: rtl/vbl_meas_seq_chk.sv
module vbl_meas_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       v_level,
   input logic       blank_o,
   input logic       leak_o,
   input logic [2:0] cut_o,
   input logic       white_o,
   input logic [2:0] ch_pass_o,
   input logic       discharge_o
);
   p_rise_opens_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(v_level) |=> blank_o);

   p_strobe_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({leak_o, cut_o, white_o}));

   p_strobe_in_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (leak_o || (cut_o != 3'b000) || white_o) |-> blank_o);

   p_dis_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      discharge_o |-> (blank_o && ch_pass_o == 3'b000));

   p_dis_needs_v_r7: assert property (@(posedge clk) disable iff (!rst_n)
      discharge_o |-> $past(v_level));

   p_open_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !blank_o |-> (ch_pass_o == 3'b111 && !discharge_o));
endmodule

bind vbl_meas_seq vbl_meas_seq_chk chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .v_level     (v_level),
   .blank_o     (blank_o),
   .leak_o      (leak_o),
   .cut_o       (cut_o),
   .white_o     (white_o),
   .ch_pass_o   (ch_pass_o),
   .discharge_o (discharge_o)
);

// File: tb/vbl_meas_seq_tb.sv
`timescale 1ns/1ps
module vbl_meas_seq_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       h_pulse = 1'b0;
   logic       v_level = 1'b0;
   logic [2:0] std_sel = 3'b000;
   logic       blank_o, bright_dis_o, leak_o, white_o, discharge_o;
   logic [2:0] cut_o, ch_pass_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   vbl_meas_seq dut_i (
      .clk(clk), .rst_n(rst_n), .h_pulse(h_pulse), .v_level(v_level),
      .std_sel(std_sel), .blank_o(blank_o), .bright_dis_o(bright_dis_o),
      .leak_o(leak_o), .cut_o(cut_o), .white_o(white_o),
      .ch_pass_o(ch_pass_o), .discharge_o(discharge_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int base_of(input int s);
      case (s)
         1: return 16;
         2: return 22;
         4: return 38;
         5: return 32;
         6: return 44;
         default: return 19;
      endcase
   endfunction

   function automatic bit prog_of(input int s);
      return (s == 4) || (s == 5) || (s == 6);
   endfunction

   // Check every output against arithmetic expectations for line count k.
   task automatic expect_line(input int s, input int vlen, input int k, input bit v_hi,
                              input string stag);
      int  sp, b, wl, endk, thr;
      bit  valid, bl, dis, lk, wh;
      int  cut, pass;
      sp    = prog_of(s) ? 2 : 1;
      b     = base_of(s);
      wl    = b + 4 * sp - 1;
      thr   = prog_of(s) ? 57 : 29;
      valid = vlen >= (prog_of(s) ? 8 : 4);
      endk  = (wl + 1 > vlen + 1) ? wl + 1 : vlen + 1;
      if (v_hi)       bl = 1'b1;
      else if (valid) bl = k < endk;
      else            bl = 1'b0;
      dis  = v_hi && (k > thr);
      lk   = bl && k <= wl && k < b;
      cut  = 0;
      for (int c = 0; c < 3; c++)
         if (bl && k >= b + c * sp && k < b + (c + 1) * sp) cut = 1 << c;
      wh   = bl && k >= b + 3 * sp && k <= wl;
      if (!bl)      pass = 7;
      else if (dis) pass = 0;
      else if (wh)  pass = 7;
      else          pass = cut;
      chk(valid ? "R6" : "R5", $sformatf("blank k=%0d", k), blank_o, bl);
      chk("R1", "bright_dis", bright_dis_o, blank_o);
      chk("R4", $sformatf("leak k=%0d", k), leak_o, lk);
      chk(stag, $sformatf("cut k=%0d sel=%0d", k, s), cut_o, cut);
      chk(stag, $sformatf("white k=%0d sel=%0d", k, s), white_o, wh);
      chk("R7", $sformatf("discharge k=%0d", k), discharge_o, dis);
      chk("R8", $sformatf("pass k=%0d", k), ch_pass_o, pass);
   endtask

   // One field: v rises, vlen H pulses with v high, then v falls, nl pulses total.
   task automatic field(input int s, input int vlen, input int nl, input bit chg,
                        input int alt, input string stag);
      @(negedge clk);
      std_sel = 3'(s);
      v_level = 1'b1;
      @(negedge clk);
      if (chg) std_sel = 3'(alt);
      chk("R1", "blank after rise", blank_o, 1);
      expect_line(s, vlen, 0, 1'b1, stag);
      for (int k = 1; k <= nl; k++) begin
         h_pulse = 1'b1;
         @(negedge clk);
         h_pulse = 1'b0;
         expect_line(s, vlen, k, k <= vlen, stag);
         if (k == vlen) v_level = 1'b0;
         @(negedge clk);
         if (k == vlen) expect_line(s, vlen, k, 1'b0, stag);
         @(negedge clk);
      end
      v_level = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "reset blank", blank_o, 0);
      chk("R8", "reset pass", ch_pass_o, 7);
      chk("R4", "reset strobes", {leak_o, cut_o, white_o}, 0);
      chk("R7", "reset discharge", discharge_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      field(0, 6, 26, 1'b0, 0, "R2");
      field(1, 5, 22, 1'b0, 0, "R2");
      field(2, 4, 28, 1'b0, 0, "R2");
      field(4, 9, 48, 1'b0, 0, "R3");
      field(5, 8, 44, 1'b0, 0, "R3");
      field(6, 10, 56, 1'b0, 0, "R3");
      field(3, 5, 25, 1'b0, 0, "R9");
      field(7, 5, 25, 1'b0, 0, "R9");
      field(7, 4, 25, 1'b0, 0, "R9");
      field(0, 3, 8, 1'b0, 0, "R5");
      field(4, 7, 12, 1'b0, 0, "R5");
      field(0, 12, 26, 1'b0, 0, "R6");
      field(0, 35, 40, 1'b0, 0, "R11");
      field(6, 60, 64, 1'b0, 0, "R11");
      field(1, 6, 22, 1'b1, 2, "R10");
      field(4, 9, 48, 1'b1, 0, "R10");
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule